// File: doc/BRIEF.md
# Direct-Mapped Translation Lookaside Buffer with Process Tags

This block holds recently used virtual-to-physical page translations so that most memory references skip the page table. The array has 64 sets and is direct-mapped. Pages are 512 bytes. A lookup is combinational. It takes a 16-bit virtual address, the current process ID and a store/load flag. It answers in the same cycle with either a hit and the physical address, or a miss. A miss only means that the translation is not cached. A separate walker must consult the page table to decide whether a page fault occurred. When the walk is done, the walker writes the translation back through the refill port.

Every entry keeps three status bits: valid, dirty and referenced. A hit sets the referenced bit. A hit by a store also sets the dirty bit. An external timer can clear all referenced bits at once. Context switches are handled in one of two ways, chosen by the system. It can flush the whole array, or it can keep the process ID stored in each entry and require it to match on lookup.

Top module: `tlb_pid_dm`

## Requirements
- R1: On a hit, bits [8:0] of `lk_paddr` equal bits [8:0] of `lk_vaddr`, and bits [15:9] hold the stored physical page number.
- R2: The virtual page number is `lk_vaddr[15:9]`. The set index is page bits [5:0] and the tag is page bit [6]. A lookup hits only if the indexed entry is valid and its tag matches. For example, after a refill of page 71 to frame 9, address 36831 translates to 5087. After a refill of page 8 to frame 2, address 4319 translates to 1247. Address 3589 (set 7, tag 0) misses against page 71.
- R3: A refill (`rf_en`) overwrites the set selected by `rf_vpn[5:0]` at the clock edge. The new entry is valid and referenced, and its dirty bit is taken from `rf_dirty`. The next lookup shows this entry.
- R4: A hitting lookup sets the entry's referenced bit at the clock edge. The bit is visible on `lk_ref` from the next cycle. A lookup with `lk_req` low changes nothing.
- R5: A hitting lookup with `lk_store` high sets the entry's dirty bit at the clock edge. `lk_dirty` shows the stored value from before the update.
- R6: `clr_ref` clears every referenced bit at the clock edge, and it takes priority over a hit's set in the same cycle.
- R7: `flush_all` invalidates every entry at the clock edge, and it takes priority over a refill in the same cycle.
- R8: When `pid_check` is 1, a hit also requires that the stored process ID equals `lk_pid`. When `pid_check` is 0, the process ID is ignored.
- R9: `lk_miss` is high exactly when `lk_req` is high and there is no hit. When there is no hit, `lk_hit`, `lk_paddr`, `lk_dirty` and `lk_ref` are 0.
- R10: After reset no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 16 | Virtual address to translate |
| lk_pid | input | 4 | Process ID of the requester |
| lk_store | input | 1 | Access is a store |
| pid_check | input | 1 | 1: compare process ID as part of the tag |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request made, translation not cached |
| lk_paddr | output | 16 | Physical address on hit |
| lk_dirty | output | 1 | Stored dirty bit of hit entry |
| lk_ref | output | 1 | Stored referenced bit of hit entry |
| rf_en | input | 1 | Write a refill entry |
| rf_vpn | input | 7 | Virtual page number being refilled |
| rf_pid | input | 4 | Process ID owning the refilled page |
| rf_ppn | input | 7 | Physical page number to store |
| rf_dirty | input | 1 | Initial dirty bit of the refilled entry |
| flush_all | input | 1 | Invalidate all entries |
| clr_ref | input | 1 | Clear all referenced bits |

## Verification
Lookup results are combinational. The bench therefore drives each request just after a falling edge and samples the outputs one nanosecond later, in the same cycle and before the next rising edge. Refill, flush, reference clear and the status-bit updates from a hit all take effect at the rising edge that ends the cycle. The bench observes them with a lookup issued in a later cycle. The status bits are checked through `lk_ref` and `lk_dirty`, which show the values stored before that cycle's update.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W   = 16;
  parameter int PA_W   = 16;
  parameter int OFS_W  = 9;
  parameter int IDX_W  = 6;
  parameter int PID_W  = 4;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int NSETS = 1 << IDX_W;

  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic             refd;
    logic [PID_W-1:0] pid;
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
  } tlb_entry_t;

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFS_W];
  endfunction

  function automatic logic [IDX_W-1:0] set_of(input logic [VPN_W-1:0] vpn);
    return vpn[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1:IDX_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFS_W-1:0] ofs);
    return {ppn, ofs};
  endfunction
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
  import tlb_pkg::*;
(
  input  tlb_entry_t       ent,
  input  logic [TAG_W-1:0] tag,
  input  logic [PID_W-1:0] pid,
  input  logic             pid_check,
  output logic             match
);
  logic tag_eq;
  logic pid_ok;

  always_comb begin
    tag_eq = (ent.tag == tag);
    pid_ok = !pid_check || (ent.pid == pid);
    match  = ent.valid && tag_eq && pid_ok;
  end
endmodule

// File: rtl/tlb_set_array.sv
module tlb_set_array
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             clr_ref,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_entry_t       wr_ent,
  input  logic             touch,
  input  logic             touch_store,
  input  logic [IDX_W-1:0] rd_idx,
  output tlb_entry_t       rd_ent
);
  tlb_entry_t [NSETS-1:0] ents;
  logic [NSETS-1:0] valid_vec;
  logic [NSETS-1:0] ref_vec;
  logic [NSETS-1:0] dirty_vec;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    tlb_entry_t q;
    logic sel_wr;
    logic sel_rd;
    assign sel_wr = wr_en && (wr_idx == IDX_W'(s));
    assign sel_rd = touch && (rd_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (flush) begin
        q.valid <= 1'b0;
        q.refd  <= 1'b0;
        q.dirty <= 1'b0;
      end else if (sel_wr) begin
        q <= wr_ent;
      end else begin
        if (clr_ref)     q.refd <= 1'b0;
        else if (sel_rd) q.refd <= 1'b1;
        if (sel_rd && touch_store) q.dirty <= 1'b1;
      end
    end

    assign ents[s]      = q;
    assign valid_vec[s] = q.valid;
    assign ref_vec[s]   = q.refd;
    assign dirty_vec[s] = q.dirty;
  end

  assign rd_ent = ents[rd_idx];

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)); // R7
  AST_REFCLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ref && !wr_en && !flush) |=> (ref_vec == '0)); // R6
  AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_vec[$past(wr_idx)]); // R3
  AST_TOUCH_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && !flush && !clr_ref && !(wr_en && wr_idx == rd_idx)) |=> ref_vec[$past(rd_idx)]); // R4
  AST_STORE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && touch_store && !flush && !(wr_en && wr_idx == rd_idx)) |=> dirty_vec[$past(rd_idx)]); // R5
endmodule

// File: rtl/tlb_pid_dm.sv
module tlb_pid_dm
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_store,
  input  logic             pid_check,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_dirty,
  output logic             lk_ref,
  input  logic             rf_en,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PID_W-1:0] rf_pid,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_dirty,
  input  logic             flush_all,
  input  logic             clr_ref
);
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  tlb_entry_t       rd_ent;
  tlb_entry_t       new_ent;
  logic             match;
  logic             hit_evt;
  logic             store_hit_evt;

  assign lk_vpn = vpn_of(lk_vaddr);
  assign lk_idx = set_of(lk_vpn);
  assign lk_tag = tag_of(lk_vpn);

  always_comb begin
    new_ent       = '0;
    new_ent.valid = 1'b1;
    new_ent.refd  = 1'b1;
    new_ent.dirty = rf_dirty;
    new_ent.pid   = rf_pid;
    new_ent.tag   = tag_of(rf_vpn);
    new_ent.ppn   = rf_ppn;
  end

  tlb_set_array i_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_all),
    .clr_ref    (clr_ref),
    .wr_en      (rf_en),
    .wr_idx     (set_of(rf_vpn)),
    .wr_ent     (new_ent),
    .touch      (hit_evt),
    .touch_store(lk_store),
    .rd_idx     (lk_idx),
    .rd_ent     (rd_ent)
  );

  tlb_tag_match i_match (
    .ent      (rd_ent),
    .tag      (lk_tag),
    .pid      (lk_pid),
    .pid_check(pid_check),
    .match    (match)
  );

  assign hit_evt       = lk_req && match;
  assign store_hit_evt = hit_evt && lk_store;

  always_comb begin
    lk_hit   = hit_evt;
    lk_miss  = lk_req && !match;
    lk_paddr = hit_evt ? join_pa(rd_ent.ppn, lk_vaddr[OFS_W-1:0]) : '0;
    lk_dirty = hit_evt && rd_ent.dirty;
    lk_ref   = hit_evt && rd_ent.refd;
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> (!lk_hit && !lk_miss)); // R9
  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !rf_en) |=> !lk_hit); // R7
  AST_STORE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (store_hit_evt && !flush_all && !rf_en && !clr_ref && lk_req && $stable(lk_vaddr)) |=> (!lk_hit || lk_dirty)); // R5
endmodule

// File: tb/test_tlb_pid_dm.sv
`timescale 1ns/1ps
module test_tlb_pid_dm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 0, lk_store = 0, pid_check = 1;
  logic [15:0] lk_vaddr = '0;
  logic [3:0] lk_pid = '0, rf_pid = '0;
  logic lk_hit, lk_miss, lk_dirty, lk_ref;
  logic [15:0] lk_paddr;
  logic rf_en = 0, rf_dirty = 0, flush_all = 0, clr_ref = 0;
  logic [6:0] rf_vpn = '0, rf_ppn = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlb_pid_dm i_tlb_pid_dm (.*);

  typedef struct packed {
    logic        op_rf;
    logic [15:0] va;
    logic [3:0]  pid;
    logic        st;
    logic        pchk;
    logic [6:0]  ppn;
    logic        dty;
    logic        eh;
    logic [15:0] ep;
    logic        ed;
    logic        er;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 16'd36352, 4'd3, 1'b0, 1'b1, 7'd9, 1'b0, 1'b0, 16'd0,    1'b0, 1'b0},
    '{1'b1, 16'd4096,  4'd3, 1'b0, 1'b1, 7'd2, 1'b1, 1'b0, 16'd0,    1'b0, 1'b0},
    '{1'b0, 16'd36831, 4'd3, 1'b0, 1'b1, 7'd0, 1'b0, 1'b1, 16'd5087, 1'b0, 1'b1},
    '{1'b0, 16'd4319,  4'd3, 1'b0, 1'b1, 7'd0, 1'b0, 1'b1, 16'd1247, 1'b1, 1'b1},
    '{1'b0, 16'd3589,  4'd3, 1'b0, 1'b1, 7'd0, 1'b0, 1'b0, 16'd0,    1'b0, 1'b0},
    '{1'b0, 16'd36831, 4'd5, 1'b0, 1'b1, 7'd0, 1'b0, 1'b0, 16'd0,    1'b0, 1'b0},
    '{1'b0, 16'd36831, 4'd5, 1'b0, 1'b0, 7'd0, 1'b0, 1'b1, 16'd5087, 1'b0, 1'b1},
    '{1'b0, 16'd36831, 4'd3, 1'b1, 1'b1, 7'd0, 1'b0, 1'b1, 16'd5087, 1'b0, 1'b1},
    '{1'b0, 16'd36831, 4'd3, 1'b0, 1'b1, 7'd0, 1'b0, 1'b1, 16'd5087, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_ctl();
    lk_req = 0; lk_store = 0; rf_en = 0; flush_all = 0; clr_ref = 0; pid_check = 1;
  endtask

  task automatic lookup(input logic [15:0] va, input logic [3:0] pid,
                        input logic st, input logic pchk);
    @(negedge clk);
    idle_ctl();
    lk_req = 1; lk_vaddr = va; lk_pid = pid; lk_store = st; pid_check = pchk;
    #1;
  endtask

  task automatic refill(input logic [6:0] vpn, input logic [3:0] pid,
                        input logic [6:0] ppn, input logic dty);
    @(negedge clk);
    idle_ctl();
    rf_en = 1; rf_vpn = vpn; rf_pid = pid; rf_ppn = ppn; rf_dirty = dty;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R10: empty after reset
    lookup(16'd36831, 4'd3, 0, 1);
    check("R10 hit", {31'd0, lk_hit}, 0);
    check("R9 miss", {31'd0, lk_miss}, 1);
    check("R9 paddr", {16'd0, lk_paddr}, 0);

    foreach (VECS[i]) begin
      if (VECS[i].op_rf) begin
        refill(VECS[i].va[15:9], VECS[i].pid, VECS[i].ppn, VECS[i].dty);
      end else begin
        lookup(VECS[i].va, VECS[i].pid, VECS[i].st, VECS[i].pchk);
        check("R2/R8 hit", {31'd0, lk_hit}, {31'd0, VECS[i].eh});
        check("R9 miss", {31'd0, lk_miss}, {31'd0, !VECS[i].eh});
        check("R1 paddr", {16'd0, lk_paddr}, {16'd0, VECS[i].ep});
        check("R3/R5 dirty", {31'd0, lk_dirty}, {31'd0, VECS[i].ed});
        check("R3/R4 ref", {31'd0, lk_ref}, {31'd0, VECS[i].er});
      end
    end

    // R6: clear all reference bits, hit in the same cycle loses
    @(negedge clk); idle_ctl(); clr_ref = 1; lk_req = 1; lk_vaddr = 16'd4319; lk_pid = 3;
    lookup(16'd36831, 4'd3, 0, 1);
    check("R6 ref page71", {31'd0, lk_ref}, 0);
    lookup(16'd4319, 4'd3, 0, 1);
    check("R6 ref page8", {31'd0, lk_ref}, 0);
    // R4: the previous hit set it
    lookup(16'd4319, 4'd3, 0, 1);
    check("R4 ref set by hit", {31'd0, lk_ref}, 1);

    // R4: no request leaves ref untouched
    @(negedge clk); idle_ctl(); clr_ref = 1;
    @(negedge clk); idle_ctl(); lk_vaddr = 16'd4319; #1;
    check("R9 idle hit", {31'd0, lk_hit}, 0);
    check("R9 idle miss", {31'd0, lk_miss}, 0);
    lookup(16'd4319, 4'd3, 0, 1);
    check("R4 idle no touch", {31'd0, lk_ref}, 0);

    // R7: flush beats refill in the same cycle
    refill(7'd8, 4'd3, 7'd2, 0);
    flush_all = 1;
    lookup(16'd4319, 4'd3, 0, 1);
    check("R7 flushed page8", {31'd0, lk_hit}, 0);
    lookup(16'd36831, 4'd3, 0, 1);
    check("R7 flushed page71", {31'd0, lk_hit}, 0);

    // R3: refill after flush with other frame, offset pass-through R1
    refill(7'd71, 4'd1, 7'd127, 0);
    lookup(16'd36352 + 16'd511, 4'd1, 0, 1);
    check("R3 refill hit", {31'd0, lk_hit}, 1);
    check("R1 offset", {16'd0, lk_paddr}, 32'd65535);

    @(negedge clk); idle_ctl();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule